// File: doc/BRIEF.md
# Modulo Address Pointer Update Unit

This block computes the next value of an address pointer that walks a circular buffer. Each pointer register is tied to a base register with the same index. It picks one of several modulus registers through a two-bit field in a control register. The buffer is the window from base to base plus modulus minus one. The base only has to be aligned to the access width, so it need not sit on a power-of-two boundary.

On every update the unit turns the request into a signed byte step. The step is one access width, or a signed offset count multiplied by the access width. The unit adds the step to the current pointer and folds the result back into the window when it falls outside. The pointer from before the update appears as the effective address in the same cycle. The new pointer is written on the clock edge.

A linear mode skips the folding. Configurations whose modulo result would be undefined are flagged, and the update is then suppressed.

Top module: `modaddr_unit`

## Requirements
- R1: After reset, every pointer, base and modulus register and the control register are zero. Because the modulus is zero, a modulo-mode request raises `err_o`, and an update then leaves the pointer at zero.
- R2: Register writes are selected by `wr_sel_i`, with 0 = pointer, 1 = base and 2 = modulus, each indexed by `wr_idx_i`, and 3 = control register. Pointer p always uses base p. It uses the modulus register whose index is held in control bits [2p+1:2p].
- R3: Access width code `upd_width_i` 0/1/2/3 means 1/2/4/8 bytes. The step is one width when `upd_use_off_i` = 0. Otherwise it is the signed `upd_off_i` times the width. `upd_dec_i` = 1 subtracts the step instead of adding it. A result that stays inside the window is returned unchanged.
- R4: In modulo mode, a result at or above base+modulus returns result minus modulus. A result below the base returns result plus modulus.
- R5: When `upd_linear_i` = 1, `next_o` is pointer plus the signed step modulo 2^32, and `err_o` = 0.
- R6: In modulo mode, `err_o` = 1 in any of three cases: the magnitude of the step exceeds the modulus, the modulus is smaller than the access width, or the modulus is not a multiple of the access width.
- R7: `ea_o` shows the current value of pointer `upd_idx_i`. With `upd_en_i` = 1 and `err_o` = 0, that pointer takes the value of `next_o` on the rising clock edge.
- R8: With `upd_en_i` = 1 and `err_o` = 1, the pointer keeps its value.
- R9: A window that ends exactly at address 2^32 wraps correctly. No carry out of bit 31 is lost in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register kind: pointer, base, modulus, control |
| wr_idx_i | input | 2 | Register index for the write |
| wr_data_i | input | 32 | Write data |
| upd_en_i | input | 1 | Commit the pointer update on this edge |
| upd_idx_i | input | 2 | Pointer being used and updated |
| upd_dec_i | input | 1 | 1 = subtract step, 0 = add step |
| upd_use_off_i | input | 1 | 1 = scaled offset step, 0 = one access width |
| upd_off_i | input | 32 | Signed offset count |
| upd_width_i | input | 2 | Access width code |
| upd_linear_i | input | 1 | Bypass the modulo folding |
| ea_o | output | 32 | Effective address (pointer before update) |
| next_o | output | 32 | Computed next pointer |
| err_o | output | 1 | Undefined-configuration flag |

## Verification
Every access width is swept over three modulus sizes. The four pointers each get a different base and are routed to a different modulus register, so a wrong pairing or a wrong control field shows up as a wrong fold point. Within each window, every aligned start position is stepped by every offset count from one beyond minus the window size to one beyond plus it, in both directions. This covers in-window results, folds above and below the window, and too-large offsets, which must be flagged and must leave the pointer unchanged. One pointer's window ends exactly at 2^32 to expose carry loss. Linear-mode cases start outside any window and cross the 32-bit boundary. Unaligned and undersized moduli check the remaining error conditions.

// File: rtl/modaddr_pkg.sv
package modaddr_pkg;
  typedef enum logic [1:0] {
    SEL_PTR  = 2'd0,
    SEL_BASE = 2'd1,
    SEL_MOD  = 2'd2,
    SEL_CTL  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/modaddr_bank.sv
module modaddr_bank
  import modaddr_pkg::*;
#(
  parameter int NUM_PTR = 4,
  parameter int NUM_MOD = 4,
  parameter int AW      = 32,
  localparam int IW     = $clog2(NUM_PTR),
  localparam int MSW    = $clog2(NUM_MOD),
  localparam int WIW    = (IW > MSW) ? IW : MSW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  reg_sel_e       wr_sel_i,
  input  logic [WIW-1:0] wr_idx_i,
  input  logic [AW-1:0]  wr_data_i,
  input  logic           upd_en_i,
  input  logic [IW-1:0]  upd_idx_i,
  input  logic [AW-1:0]  upd_ptr_i,
  output logic [AW-1:0]  ptr_o,
  output logic [AW-1:0]  base_o,
  output logic [AW-1:0]  mod_o
);
  localparam int CW = NUM_PTR * MSW;

  logic [AW-1:0]  ptr_q  [NUM_PTR];
  logic [AW-1:0]  base_q [NUM_PTR];
  logic [AW-1:0]  mod_q  [NUM_MOD];
  logic [CW-1:0]  ctl_q;
  logic [MSW-1:0] msel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_PTR; i++) begin
        ptr_q[i]  <= '0;
        base_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_PTR; i++) begin
        // software write wins over a same-cycle update
        if (wr_en_i && wr_sel_i == SEL_PTR && wr_idx_i == WIW'(i))
          ptr_q[i] <= wr_data_i;
        else if (upd_en_i && upd_idx_i == IW'(i))
          ptr_q[i] <= upd_ptr_i;
        if (wr_en_i && wr_sel_i == SEL_BASE && wr_idx_i == WIW'(i))
          base_q[i] <= wr_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < NUM_MOD; j++) mod_q[j] <= '0;
    end else begin
      for (int j = 0; j < NUM_MOD; j++)
        if (wr_en_i && wr_sel_i == SEL_MOD && wr_idx_i == WIW'(j))
          mod_q[j] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             ctl_q <= '0;
    else if (wr_en_i && wr_sel_i == SEL_CTL) ctl_q <= wr_data_i[CW-1:0];
  end

  assign msel   = ctl_q[upd_idx_i*MSW +: MSW];
  assign ptr_o  = ptr_q[upd_idx_i];
  assign base_o = base_q[upd_idx_i];
  assign mod_o  = mod_q[msel];
endmodule

// File: rtl/modaddr_calc.sv
module modaddr_calc #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] ptr_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] mod_i,
  input  logic [AW-1:0] off_i,
  input  logic [1:0]    width_i,
  input  logic          dec_i,
  input  logic          use_off_i,
  input  logic          linear_i,
  output logic [AW-1:0] next_o,
  output logic          err_o
);
  localparam int XW = AW + 6;

  logic signed [XW-1:0] off_x, step, delta, ptr_x, base_x, mod_x, lim_x, raw, fold;
  logic        [XW-1:0] mag, wbytes;
  logic                 bad_mag, bad_small, bad_align;

  always_comb begin
    wbytes = XW'(1) << width_i;
    off_x  = {{(XW-AW){off_i[AW-1]}}, off_i};
    step   = use_off_i ? (off_x <<< width_i) : signed'(wbytes);
    delta  = dec_i ? -step : step;
    mag    = delta[XW-1] ? unsigned'(-delta) : unsigned'(delta);
    ptr_x  = signed'({{(XW-AW){1'b0}}, ptr_i});
    base_x = signed'({{(XW-AW){1'b0}}, base_i});
    mod_x  = signed'({{(XW-AW){1'b0}}, mod_i});
    lim_x  = base_x + mod_x;
    raw    = ptr_x + delta;
    if (raw >= lim_x)      fold = raw - mod_x;
    else if (raw < base_x) fold = raw + mod_x;
    else                   fold = raw;
  end

  assign bad_mag   = mag > unsigned'(mod_x);
  assign bad_small = unsigned'(mod_x) < wbytes;
  assign bad_align = (unsigned'(mod_x) & (wbytes - XW'(1))) != '0;
  assign err_o     = !linear_i && (bad_mag || bad_small || bad_align);
  assign next_o    = linear_i ? raw[AW-1:0] : fold[AW-1:0];
endmodule

// File: rtl/modaddr_unit.sv
module modaddr_unit
  import modaddr_pkg::*;
#(
  parameter int NUM_PTR = 4,
  parameter int NUM_MOD = 4,
  parameter int AW      = 32,
  localparam int IW     = $clog2(NUM_PTR),
  localparam int MSW    = $clog2(NUM_MOD),
  localparam int WIW    = (IW > MSW) ? IW : MSW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [1:0]     wr_sel_i,
  input  logic [WIW-1:0] wr_idx_i,
  input  logic [AW-1:0]  wr_data_i,
  input  logic           upd_en_i,
  input  logic [IW-1:0]  upd_idx_i,
  input  logic           upd_dec_i,
  input  logic           upd_use_off_i,
  input  logic [AW-1:0]  upd_off_i,
  input  logic [1:0]     upd_width_i,
  input  logic           upd_linear_i,
  output logic [AW-1:0]  ea_o,
  output logic [AW-1:0]  next_o,
  output logic           err_o
);
  logic [AW-1:0] ptr_w, base_w, mod_w, next_w;
  logic          err_w;

  modaddr_bank #(.NUM_PTR(NUM_PTR), .NUM_MOD(NUM_MOD), .AW(AW)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (reg_sel_e'(wr_sel_i)),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .upd_en_i  (upd_en_i && !err_w),
    .upd_idx_i (upd_idx_i),
    .upd_ptr_i (next_w),
    .ptr_o     (ptr_w),
    .base_o    (base_w),
    .mod_o     (mod_w)
  );

  modaddr_calc #(.AW(AW)) u_calc (
    .ptr_i     (ptr_w),
    .base_i    (base_w),
    .mod_i     (mod_w),
    .off_i     (upd_off_i),
    .width_i   (upd_width_i),
    .dec_i     (upd_dec_i),
    .use_off_i (upd_use_off_i),
    .linear_i  (upd_linear_i),
    .next_o    (next_w),
    .err_o     (err_w)
  );

  assign ea_o   = ptr_w;
  assign next_o = next_w;
  assign err_o  = err_w;

  a_r4_stay_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_linear_i && !err_o && ea_o >= base_w && (ea_o - base_w) < mod_w)
      |-> ((next_o - base_w) < mod_w));

  a_r5_linear_no_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_linear_i |-> !err_o);

  a_r6_small_mod: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_linear_i && mod_w < (AW'(1) << upd_width_i)) |-> err_o);

  a_r7_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && !err_o && !wr_en_i)
      |=> (u_bank.ptr_q[$past(upd_idx_i)] == $past(next_o)));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && err_o && !wr_en_i)
      |=> (u_bank.ptr_q[$past(upd_idx_i)] == $past(ea_o)));
endmodule

// File: tb/sim_modaddr_unit.sv
`timescale 1ns/1ps
module sim_modaddr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [1:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        upd_en = 1'b0;
  logic [1:0]  upd_idx = '0;
  logic        upd_dec = 1'b0;
  logic        upd_use_off = 1'b0;
  logic [31:0] upd_off = '0;
  logic [1:0]  upd_width = '0;
  logic        upd_linear = 1'b0;
  logic [31:0] ea, nxt;
  logic        err;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  longint bb [4];
  longint mm [4];
  int     sel [4];

  modaddr_unit u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .upd_en_i(upd_en), .upd_idx_i(upd_idx), .upd_dec_i(upd_dec),
    .upd_use_off_i(upd_use_off), .upd_off_i(upd_off), .upd_width_i(upd_width),
    .upd_linear_i(upd_linear),
    .ea_o(ea), .next_o(nxt), .err_o(err)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic model(input longint p, input longint b, input longint m, input longint off,
                       input int w, input bit dec, input bit useo, input bit lin,
                       output longint r, output bit e);
    longint wb, d, mag;
    wb  = longint'(1) << w;
    d   = useo ? off * wb : wb;
    if (dec) d = -d;
    mag = (d < 0) ? -d : d;
    r   = p + d;
    e   = !lin && (mag > m || m < wb || (m % wb) != 0);
    if (!lin) begin
      if (r >= b + m)  r = r - m;
      else if (r < b)  r = r + m;
    end
    r = r & 64'hFFFF_FFFF;
  endtask

  // entered and left on a falling edge
  task automatic wreg(input int s, input int idx, input longint d);
    wr_en = 1'b1; wr_sel = 2'(s); wr_idx = 2'(idx); wr_data = d[31:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic upd(input int idx, input longint start, input longint b, input longint m,
                     input longint off, input int w, input bit dec, input bit useo,
                     input bit lin, input string tag);
    longint x; bit e;
    model(start, b, m, off, w, dec, useo, lin, x, e);
    upd_idx = 2'(idx); upd_off = off[31:0]; upd_width = 2'(w); upd_dec = dec;
    upd_use_off = useo; upd_linear = lin; upd_en = 1'b1;
    #1;
    chk(err === e, "R6", longint'(err), longint'(e));
    if (!e) chk(nxt === x[31:0], tag, longint'(nxt), x);
    chk(ea === start[31:0], "R7", longint'(ea), start);
    @(negedge clk);
    upd_en = 1'b0;
    #1;
    if (e) chk(ea === start[31:0], "R8", longint'(ea), start);
    else   chk(ea === x[31:0], "R7", longint'(ea), x);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    longint wbv, m, b, st, raw;
    int n;
    string tag;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    #1;
    chk(ea === 32'h0, "R1", longint'(ea), 0);
    chk(err === 1'b1, "R1", longint'(err), 1);
    upd_en = 1'b1;
    @(negedge clk);
    upd_en = 1'b0;
    #1;
    chk(ea === 32'h0, "R1", longint'(ea), 0);
    @(negedge clk);

    // R2: pointer p selects modulus register 3-p through bits [2p+1:2p]
    for (int p = 0; p < 4; p++) sel[p] = 3 - p;
    wreg(3, 0, 64'h1B);

    for (int w = 0; w < 4; w++) begin
      wbv = longint'(1) << w;
      for (int mv = 1; mv <= 3; mv++) begin
        for (int j = 0; j < 4; j++) begin
          mm[j] = (mv + j) * wbv;
          wreg(2, j, mm[j]);
        end
        for (int p = 0; p < 4; p++) begin
          if (p == 3) bb[p] = 64'h1_0000_0000 - mm[sel[p]];
          else        bb[p] = 64'h40 + 64'h100 * p + 3 * wbv;
          wreg(1, p, bb[p]);
        end
        // R2: step from the last slot lands on the paired base
        for (int p = 0; p < 4; p++) begin
          st = bb[p] + mm[sel[p]] - wbv;
          wreg(0, p, st);
          upd(p, st, bb[p], mm[sel[p]], 0, w, 1'b0, 1'b0, 1'b0, "R2");
        end
        for (int p = 0; p < 4; p++) begin
          m = mm[sel[p]]; b = bb[p]; n = int'(m / wbv);
          for (int pos = 0; pos < n; pos++) begin
            st = b + pos * wbv;
            for (int dir = 0; dir < 2; dir++) begin
              raw = st + (dir ? -wbv : wbv);
              tag = (p == 3) ? "R9" : ((raw < b || raw >= b + m) ? "R4" : "R3");
              wreg(0, p, st);
              upd(p, st, b, m, 0, w, dir[0], 1'b0, 1'b0, tag);
              for (int k = -n - 1; k <= n + 1; k++) begin
                raw = st + (dir ? -1 : 1) * k * wbv;
                tag = (p == 3) ? "R9" : ((raw < b || raw >= b + m) ? "R4" : "R3");
                wreg(0, p, st);
                upd(p, st, b, m, k, w, dir[0], 1'b1, 1'b0, tag);
              end
            end
          end
        end
      end
    end

    // R6: unaligned modulus and undersized modulus on pointer 3 (uses modulus 0)
    wreg(1, 3, 64'h800);
    for (int w = 1; w < 4; w++) begin
      wbv = longint'(1) << w;
      wreg(2, 0, 3 * wbv + 1);
      wreg(0, 3, 64'h800);
      upd(3, 64'h800, 64'h800, 3 * wbv + 1, 0, w, 1'b0, 1'b0, 1'b0, "R6");
    end
    wreg(2, 0, 4);
    wreg(0, 3, 64'h800);
    upd(3, 64'h800, 64'h800, 4, 0, 3, 1'b0, 1'b0, 1'b0, "R6");

    // R5: linear mode, pointer outside any window, crossing 2^32
    wreg(0, 1, 5);
    upd(1, 5, bb[1], mm[sel[1]], -3, 2, 1'b0, 1'b1, 1'b1, "R5");
    wreg(0, 1, 64'hFFFF_FFFC);
    upd(1, 64'hFFFF_FFFC, bb[1], mm[sel[1]], 0, 3, 1'b0, 1'b0, 1'b1, "R5");
    wreg(2, 2, 0);
    wreg(0, 1, 64'h1234);
    upd(1, 64'h1234, bb[1], 0, 7, 1, 1'b1, 1'b1, 1'b1, "R5");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule